// File: doc/BRIEF.md
# Mean-Subtracted PCA Projection Engine

This block turns one test signal into a short feature vector. It holds three stores: a mean vector of n samples, a test vector of n samples, and a coefficient matrix of m rows by n columns. After a start pulse, it subtracts the mean element from each test sample. It multiplies each difference by the matching coefficient and sums the products of each row. The result is m signed dot products, one per coefficient row.

A host fills the three stores through one write port, selecting the store and the address on each write. It then pulses start and waits for the done flag. Finally it reads the m results one at a time through an index input. The datapath accepts a new multiply-accumulate on every cycle of a run, so a projection takes m·n cycles plus a fixed pipeline latency. Samples and coefficients are signed two's-complement words. Each result is kept at a width that cannot overflow for any input.

Top module: `pca_proj_engine`

## Requirements
- R1: Each result element is the sum over j of (test[j] − mean[j]) × coef[r][j]; the mean element is subtracted before the multiply, so a test vector equal to the mean vector gives all-zero results.
- R2: Result index r (selected by `rd_idx`, 0 ≤ r < NUM_ROWS) holds the dot product with coefficient row r, where coefficient element (r, j) is written at flat address r·VEC_LEN + j; an index of NUM_ROWS or more reads zero.
- R3: Samples, means and coefficients are signed two's-complement SAMPLE_W-bit words, and each result is exact at width 2·SAMPLE_W + 1 + ceil(log2(VEC_LEN)), including when every difference and coefficient is at its extreme.
- R4: A write with `wr_en` high stores `wr_data` into the store chosen by `wr_sel` (0 = mean, 1 = test, 2 = coefficients) at `wr_addr`; `wr_sel` = 3 and addresses outside the chosen store are ignored.
- R5: One multiply-accumulate is issued per cycle with no gaps: `busy` rises on the clock edge that accepts start, and `done` rises, with `busy` falling, exactly NUM_ROWS·VEC_LEN + 4 edges later.
- R6: Each row's sum starts from zero, so no result carries any part of another row or of an earlier run.
- R7: `done` stays high until the next accepted start, clears on the edge that accepts it, and is never high together with `busy`.
- R8: A start pulse that arrives while `busy` is high has no effect on timing or results.
- R9: Writes that arrive while `busy` is high are ignored and leave all three stores unchanged.
- R10: After reset `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Store write strobe |
| wr_sel | input | 2 | Store select: 0 mean, 1 test, 2 coefficients, 3 none |
| wr_addr | input | ADDR_W | Element address (flat r·VEC_LEN + j for coefficients) |
| wr_data | input | SAMPLE_W | Signed word to store |
| start | input | 1 | Start pulse, accepted only when idle |
| busy | output | 1 | Projection in progress |
| done | output | 1 | Results valid, held until next start |
| rd_idx | input | RW | Result row to read |
| rd_data | output | ACC_W | Signed result of the selected row |

## Verification
The projection is tried with a test vector equal to the mean, which separates a missing or misplaced subtraction from a correct one. A sparse matrix with one all-zero row shows whether rows are mapped and cleared correctly. Vectors set to the extreme signed values expose truncation or lost sign in the wide sum. Random signed data over several runs compares full sums, and a restart without reloading shows that the stores were not touched by writes made during a run. A reference model runs beside the design and checks busy and done on every clock. This catches gaps in issue, extra latency, and restarts caused by a start pulse given mid-run.

// File: rtl/pca_pkg.sv
package pca_pkg;

  typedef enum logic [1:0] {
    SEL_MEAN = 2'd0,
    SEL_TEST = 2'd1,
    SEL_COEF = 2'd2,
    SEL_NONE = 2'd3
  } store_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } seq_state_e;

  function automatic int idx_width(input int count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction

  function automatic int acc_width(input int sample_w, input int vec_len);
    return 2 * sample_w + 1 + idx_width(vec_len);
  endfunction

endpackage

// File: rtl/pca_vec_store.sv
module pca_vec_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 300,
  parameter int AW     = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam logic [AW:0] DEPTH_L = (AW+1)'(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic              wr_hit;
  logic [DATA_W-1:0] rdata_q;

  assign wr_hit = we && ({1'b0, waddr} < DEPTH_L);

  always_ff @(posedge clk) begin
    if (wr_hit) begin
      mem_q[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (re) begin
      rdata_q <= mem_q[raddr];
    end
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/pca_seq.sv
module pca_seq import pca_pkg::*; #(
  parameter  int N  = 300,
  parameter  int M  = 4,
  localparam int CW = idx_width(N),
  localparam int RW = idx_width(M),
  localparam int AW = idx_width(N * M)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          fin,
  output logic          busy,
  output logic          done,
  output logic          issue_v,
  output logic [CW-1:0] issue_col,
  output logic [RW-1:0] issue_row,
  output logic [AW-1:0] issue_flat,
  output logic          issue_first,
  output logic          issue_last,
  output logic          issue_final
);

  localparam logic [CW-1:0] COL_LAST = CW'(N - 1);
  localparam logic [RW-1:0] ROW_LAST = RW'(M - 1);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] col_q, col_d;
  logic [RW-1:0] row_q, row_d;
  logic [AW-1:0] flat_q, flat_d;
  logic          done_q, done_d;
  logic          cnt_en;
  logic          col_last, is_final;

  assign col_last = (col_q == COL_LAST);
  assign is_final = col_last && (row_q == ROW_LAST);

  // next-state logic
  always_comb begin
    state_d = state_q;
    col_d   = col_q;
    row_d   = row_q;
    flat_d  = flat_q;
    done_d  = done_q;
    cnt_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_RUN;
          col_d   = '0;
          row_d   = '0;
          flat_d  = '0;
          done_d  = 1'b0;
          cnt_en  = 1'b1;
        end
      end
      ST_RUN: begin
        if (is_final) begin
          state_d = ST_DRAIN;
        end else begin
          cnt_en = 1'b1;
          flat_d = flat_q + 1'b1;
          if (col_last) begin
            col_d = '0;
            row_d = row_q + 1'b1;
          end else begin
            col_d = col_q + 1'b1;
          end
        end
      end
      ST_DRAIN: begin
        if (fin) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      row_q  <= '0;
      flat_q <= '0;
    end else if (cnt_en) begin
      col_q  <= col_d;
      row_q  <= row_d;
      flat_q <= flat_d;
    end
  end

  assign busy        = (state_q != ST_IDLE);
  assign done        = done_q;
  assign issue_v     = (state_q == ST_RUN);
  assign issue_col   = col_q;
  assign issue_row   = row_q;
  assign issue_flat  = flat_q;
  assign issue_first = (col_q == '0);
  assign issue_last  = col_last;
  assign issue_final = is_final;

  // R7: done and busy are exclusive
  p_busy_done_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R7: done holds until a start is seen
  p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  // R8: a start during a run does not restart the sequence
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> !(state_q == ST_RUN && flat_q == '0));

  // R8: a run only begins on a start pulse
  p_rise_from_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R2: counters stay inside the matrix
  p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (col_q <= COL_LAST) && (row_q <= ROW_LAST));

endmodule

// File: rtl/pca_mac.sv
module pca_mac import pca_pkg::*; #(
  parameter  int SAMPLE_W = 32,
  parameter  int N        = 300,
  parameter  int M        = 4,
  localparam int RW       = idx_width(M),
  localparam int ACC_W    = acc_width(SAMPLE_W, N),
  localparam int DW       = SAMPLE_W + 1,
  localparam int PW       = 2 * SAMPLE_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                issue_v,
  input  logic [RW-1:0]       issue_row,
  input  logic                issue_first,
  input  logic                issue_last,
  input  logic                issue_final,
  input  logic [SAMPLE_W-1:0] tst_s1,
  input  logic [SAMPLE_W-1:0] mean_s1,
  input  logic [SAMPLE_W-1:0] coef_s1,
  input  logic [RW-1:0]       rd_idx,
  output logic [ACC_W-1:0]    rd_data,
  output logic                fin
);

  localparam logic [RW:0] NROWS = (RW+1)'(M);

  // stage 1: flags aligned with store read data
  logic          v1_q, first1_q, last1_q, final1_q;
  logic [RW-1:0] row1_q;
  // stage 2: difference
  logic                 v2_q, first2_q, last2_q, final2_q;
  logic [RW-1:0]        row2_q;
  logic signed [DW-1:0] diff2_q, diff_d;
  logic signed [SAMPLE_W-1:0] coef2_q;
  // stage 3: product
  logic                 v3_q, first3_q, last3_q, final3_q;
  logic [RW-1:0]        row3_q;
  logic signed [PW-1:0] prod3_q, prod_d;
  // stage 4: accumulate
  logic signed [ACC_W-1:0] acc_q, acc_d, acc_base;
  logic signed [ACC_W-1:0] result_q [M];
  logic                    fin_q;

  // valid pipeline
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q  <= 1'b0;
      v2_q  <= 1'b0;
      v3_q  <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      v1_q  <= issue_v;
      v2_q  <= v1_q;
      v3_q  <= v2_q;
      fin_q <= v3_q && final3_q;
    end
  end

  always_ff @(posedge clk) begin
    if (issue_v) begin
      row1_q   <= issue_row;
      first1_q <= issue_first;
      last1_q  <= issue_last;
      final1_q <= issue_final;
    end
  end

  assign diff_d = $signed({tst_s1[SAMPLE_W-1], tst_s1}) -
                  $signed({mean_s1[SAMPLE_W-1], mean_s1});

  always_ff @(posedge clk) begin
    if (v1_q) begin
      diff2_q  <= diff_d;
      coef2_q  <= $signed(coef_s1);
      row2_q   <= row1_q;
      first2_q <= first1_q;
      last2_q  <= last1_q;
      final2_q <= final1_q;
    end
  end

  assign prod_d = diff2_q * coef2_q;

  always_ff @(posedge clk) begin
    if (v2_q) begin
      prod3_q  <= prod_d;
      row3_q   <= row2_q;
      first3_q <= first2_q;
      last3_q  <= last2_q;
      final3_q <= final2_q;
    end
  end

  assign acc_base = first3_q ? '0 : acc_q;
  assign acc_d    = acc_base + ACC_W'(prod3_q);

  always_ff @(posedge clk) begin
    if (v3_q) begin
      acc_q <= acc_d;
    end
  end

  for (genvar r = 0; r < M; r++) begin : g_result
    always_ff @(posedge clk) begin
      if (v3_q && last3_q && (row3_q == RW'(r))) begin
        result_q[r] <= acc_d;
      end
    end
  end

  assign rd_data = ({1'b0, rd_idx} < NROWS) ? result_q[rd_idx] : '0;
  assign fin     = fin_q;

  // R5: issue from the sequencer arrives without gaps until the final element
  p_no_bubble_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (v1_q && !final1_q) |=> v1_q);

  // R5: completion is a single-cycle event
  p_fin_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |=> !fin_q);

  // R6: every row begins with a cleared sum
  p_row_starts_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (v3_q && last3_q && !final3_q) |=> (v3_q && first3_q));

endmodule

// File: rtl/pca_proj_engine.sv
module pca_proj_engine import pca_pkg::*; #(
  parameter  int SAMPLE_W = 32,
  parameter  int VEC_LEN  = 300,
  parameter  int NUM_ROWS = 4,
  localparam int ACC_W    = acc_width(SAMPLE_W, VEC_LEN),
  localparam int ADDR_W   = idx_width(VEC_LEN * NUM_ROWS),
  localparam int RW       = idx_width(NUM_ROWS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [SAMPLE_W-1:0] wr_data,
  input  logic                start,
  output logic                busy,
  output logic                done,
  input  logic [RW-1:0]       rd_idx,
  output logic [ACC_W-1:0]    rd_data
);

  localparam int CW = idx_width(VEC_LEN);

  logic                wr_ok, we_mean, we_test, we_coef;
  logic                fin;
  logic                issue_v, issue_first, issue_last, issue_final;
  logic [CW-1:0]       issue_col;
  logic [RW-1:0]       issue_row;
  logic [ADDR_W-1:0]   issue_flat, vec_raddr;
  logic [SAMPLE_W-1:0] tst_s1, mean_s1, coef_s1;

  assign wr_ok   = wr_en && !busy;
  assign we_mean = wr_ok && (store_sel_e'(wr_sel) == SEL_MEAN);
  assign we_test = wr_ok && (store_sel_e'(wr_sel) == SEL_TEST);
  assign we_coef = wr_ok && (store_sel_e'(wr_sel) == SEL_COEF);

  assign vec_raddr = ADDR_W'(issue_col);

  pca_seq #(.N(VEC_LEN), .M(NUM_ROWS)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .fin         (fin),
    .busy        (busy),
    .done        (done),
    .issue_v     (issue_v),
    .issue_col   (issue_col),
    .issue_row   (issue_row),
    .issue_flat  (issue_flat),
    .issue_first (issue_first),
    .issue_last  (issue_last),
    .issue_final (issue_final)
  );

  pca_vec_store #(.DATA_W(SAMPLE_W), .DEPTH(VEC_LEN), .AW(ADDR_W)) u_mean_store (
    .clk   (clk),
    .we    (we_mean),
    .waddr (wr_addr),
    .wdata (wr_data),
    .re    (issue_v),
    .raddr (vec_raddr),
    .rdata (mean_s1)
  );

  pca_vec_store #(.DATA_W(SAMPLE_W), .DEPTH(VEC_LEN), .AW(ADDR_W)) u_test_store (
    .clk   (clk),
    .we    (we_test),
    .waddr (wr_addr),
    .wdata (wr_data),
    .re    (issue_v),
    .raddr (vec_raddr),
    .rdata (tst_s1)
  );

  pca_vec_store #(.DATA_W(SAMPLE_W), .DEPTH(VEC_LEN * NUM_ROWS), .AW(ADDR_W)) u_coef_store (
    .clk   (clk),
    .we    (we_coef),
    .waddr (wr_addr),
    .wdata (wr_data),
    .re    (issue_v),
    .raddr (issue_flat),
    .rdata (coef_s1)
  );

  pca_mac #(.SAMPLE_W(SAMPLE_W), .N(VEC_LEN), .M(NUM_ROWS)) u_mac (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_v     (issue_v),
    .issue_row   (issue_row),
    .issue_first (issue_first),
    .issue_last  (issue_last),
    .issue_final (issue_final),
    .tst_s1      (tst_s1),
    .mean_s1     (mean_s1),
    .coef_s1     (coef_s1),
    .rd_idx      (rd_idx),
    .rd_data     (rd_data),
    .fin         (fin)
  );

  // R9: stores are written only while idle
  p_no_write_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(we_mean || we_test || we_coef));

  // R10: control outputs are idle after reset
  p_reset_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!busy && !done));

endmodule

// File: tb/pca_proj_engine_bench.sv
module pca_proj_engine_bench;

  localparam int SW     = 32;
  localparam int N      = 12;
  localparam int M      = 3;
  localparam int ACC_W  = 2 * SW + 1 + $clog2(N);
  localparam int ADDR_W = $clog2(N * M);
  localparam int RW     = 2;
  localparam int LAT    = N * M + 4;

  logic              clk, rst_n;
  logic              wr_en, start;
  logic [1:0]        wr_sel;
  logic [ADDR_W-1:0] wr_addr;
  logic [SW-1:0]     wr_data;
  logic              busy, done;
  logic [RW-1:0]     rd_idx;
  logic [ACC_W-1:0]  rd_data;

  int chk = 0;
  int fails = 0;
  bit finished = 0;

  pca_proj_engine #(.SAMPLE_W(SW), .VEC_LEN(N), .NUM_ROWS(M)) u_pca_proj_engine (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // behavioural reference model
  logic signed [SW-1:0]    m_mean [N];
  logic signed [SW-1:0]    m_test [N];
  logic signed [SW-1:0]    m_coef [N*M];
  logic signed [ACC_W-1:0] m_exp  [M];
  bit m_busy, m_done;
  int m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0;
      m_done = 0;
      m_cnt  = 0;
    end else begin
      if (wr_en && !m_busy) begin
        case (wr_sel)
          2'd0: if (int'(wr_addr) < N) m_mean[wr_addr] = wr_data;
          2'd1: if (int'(wr_addr) < N) m_test[wr_addr] = wr_data;
          2'd2: if (int'(wr_addr) < N * M) m_coef[wr_addr] = wr_data;
          default: ;
        endcase
      end
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == LAT) begin
          m_busy = 0;
          m_done = 1;
        end
      end else if (start) begin
        m_busy = 1;
        m_done = 0;
        m_cnt  = 0;
        for (int r = 0; r < M; r++) begin
          logic signed [ACC_W-1:0] s, d, c;
          s = '0;
          for (int j = 0; j < N; j++) begin
            d = m_test[j];
            d = d - ACC_W'(m_mean[j]);
            c = m_coef[r * N + j];
            s = s + d * c;
          end
          m_exp[r] = s;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [ACC_W-1:0] act,
                       input logic [ACC_W-1:0] exp);
    chk++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison of control outputs (R5, R7)
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(busy == m_busy, "R5 busy timing", ACC_W'(busy), ACC_W'(m_busy));
      check(done == m_done, "R7 done timing", ACC_W'(done), ACC_W'(m_done));
    end
  end

  task automatic wr(input logic [1:0] sel, input int addr, input logic [SW-1:0] data);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_sel  = sel;
    wr_addr = ADDR_W'(addr);
    wr_data = data;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check(done == 1'b1, tag, ACC_W'(done), ACC_W'(1));
  endtask

  task automatic check_results(input string tag);
    for (int r = 0; r < M; r++) begin
      @(negedge clk);
      rd_idx = RW'(r);
      #1;
      check(rd_data === m_exp[r], tag, rd_data, m_exp[r]);
    end
  endtask

  task automatic load_all(input int mode);
    for (int j = 0; j < N; j++) begin
      logic [SW-1:0] t, mv;
      case (mode)
        0: begin mv = '0; t = SW'(j + 1); end
        1: begin mv = $urandom(); t = mv; end
        2: begin mv = 32'h8000_0000; t = 32'h7FFF_FFFF; end
        default: begin mv = $urandom(); t = $urandom(); end
      endcase
      wr(2'd0, j, mv);
      wr(2'd1, j, t);
    end
    for (int k = 0; k < N * M; k++) begin
      logic [SW-1:0] c;
      case (mode)
        0: c = (k / N == 1) ? '0 : SW'((k % 5) - 2);
        1: c = $urandom();
        2: c = 32'h8000_0000;
        default: c = $urandom();
      endcase
      wr(2'd2, k, c);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", chk - fails, chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", '0, '1);
    finish_run();
  end

  initial begin
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_sel  = 2'd0;
    wr_addr = '0;
    wr_data = '0;
    start   = 1'b0;
    rd_idx  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check(busy == 1'b0, "R10 busy after reset", ACC_W'(busy), '0);
    check(done == 1'b0, "R10 done after reset", ACC_W'(done), '0);

    // R2 / R6: small ramp, sparse matrix with an all-zero row 1
    load_all(0);
    pulse_start();
    wait_done("R5 done after ramp run");
    check_results("R2 ramp dot products");
    rd_idx = RW'(1);
    #1;
    check(rd_data === '0, "R6 zero row gives zero", rd_data, '0);
    rd_idx = RW'(3);
    #1;
    check(rd_data === '0, "R2 index beyond rows reads zero", rd_data, '0);

    // R7: done holds while idle
    repeat (10) @(negedge clk);
    check(done == 1'b1, "R7 done held", ACC_W'(done), ACC_W'(1));

    // R1: test equal to mean gives zero
    load_all(1);
    pulse_start();
    wait_done("R5 done after equal run");
    check_results("R1 test equals mean");

    // R3: extreme values
    load_all(2);
    pulse_start();
    wait_done("R5 done after extreme run");
    check_results("R3 extreme signed sum");

    // R6: random runs, sums do not carry between runs
    for (int it = 0; it < 3; it++) begin
      load_all(3);
      pulse_start();
      wait_done("R5 done after random run");
      check_results("R6 random signed projection");
    end

    // R8: start pulses during a run
    pulse_start();
    repeat (5) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (N) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done("R8 done after ignored starts");
    check_results("R8 results after ignored starts");

    // R9: writes during a run are ignored
    pulse_start();
    wr(2'd1, 0, 32'h1234_5678);
    wr(2'd0, 1, 32'h0BAD_F00D);
    wr(2'd2, 2, 32'h7FFF_0000);
    wait_done("R9 done after busy writes");
    check_results("R9 results with busy writes");
    pulse_start();
    wait_done("R9 done on rerun");
    check_results("R9 stores unchanged on rerun");

    // R4: select 3 and out-of-range addresses are ignored
    wr(2'd3, 0, 32'h5555_5555);
    wr(2'd0, N + 2, 32'h6666_6666);
    wr(2'd1, N + 3, 32'h7777_7777);
    wr(2'd2, N * M + 1, 32'h1111_1111);
    pulse_start();
    wait_done("R4 done after ignored writes");
    check_results("R4 ignored writes leave results");

    // R4: a valid coefficient write changes only its row
    wr(2'd2, 2 * N + 4, 32'hFFFF_FFF0);
    pulse_start();
    wait_done("R4 done after coef write");
    check_results("R4 single coefficient update");

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule